// File: doc/BRIEF.md
# Looping Shift-Right Sequencer

This block performs a logical right shift of a data word by a count of 0 to 31. It moves one bit position per clock rather than through a barrel network. A start pulse captures three inputs: the operand, a 5-bit immediate count field and the low five bits of a register operand. The count register is loaded first from the immediate field. If that value is zero, the count register is reloaded on the next step from the register-operand bits. The operand is held in a working register.

While the count is nonzero, each step shifts the working register right by one, with a zero entering the top bit, and decrements the count. When the count reaches zero, the working register is copied to the result output and a one-cycle done pulse is raised. If both count sources are zero, the operand passes through unchanged. A busy flag covers the whole sequence, and a start seen while busy is dropped.

Top module: `loop_shr_seq`

## Requirements
- R1: During and directly after reset, `done` and `busy` are 0 and `result` is all zeros.
- R2: When the immediate field `imm_count` is nonzero, the result equals the operand shifted right logically by `imm_count`, and the `reg_count` input has no effect.
- R3: When `imm_count` is zero, the result equals the operand shifted right logically by `reg_count`.
- R4: Every shift step places a 0 into the most significant bit, so an all-ones operand shifted by n gives a word whose top n bits are 0 and whose other bits are 1.
- R5: When both `imm_count` and `reg_count` are zero, the result equals the operand unchanged.
- R6: If `start` is sampled at clock edge k with effective count n, `done` is 1 for exactly one cycle, following edge k+n+2.
- R7: `busy` is 1 from the edge that accepts `start` until the edge that raises `done`. A `start` sampled while `busy` is 1 is ignored: it produces no extra `done`, and it does not change the result or the timing of the running sequence.
- R8: `result` changes only at the edge that raises `done`, and holds its value until the next `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a sequence; sampled only while idle |
| operand | input | 32 | Word to be shifted |
| imm_count | input | 5 | Immediate shift count field |
| reg_count | input | 5 | Low five bits of the register operand; the fallback count |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse marking a valid result |
| result | output | 32 | Shifted word, held between completions |

## Verification
The result of a start sampled at edge k with effective count n is due in the cycle that follows edge k+n+2. The bench numbers every rising edge. For each accepted start, the driver computes that edge number together with the expected word and queues both. The monitor samples on falling edges and compares the edge number and the value whenever `done` is high. It also checks that `done` drops and `result` holds on the next falling edge. A `done` with nothing queued is a failure, and so is an item still in the queue at the end, so an ignored start that produced output would be reported.

// File: rtl/loop_shr_pkg.sv
// Package: shared types for the looping shift-right sequencer.
// Assumes: included first in compile order.
package loop_shr_pkg;

    // Sequencer phases: waiting, count-source check, shift loop.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SRC  = 2'd1,
        PH_LOOP = 2'd2
    } shr_phase_t;

endpackage

// File: rtl/loop_shr_count.sv
// Module: loadable, decrementing shift-count register with zero detect.
// Assumes: load has priority over decrement; decrement is never asserted
// when the count is zero (the controller guarantees this).
module loop_shr_count #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic [CNT_W-1:0] count,
    output logic             is_zero
);

    logic [CNT_W-1:0] count_q;

    // Update the count: clear on reset, load, or step down by one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (load) begin
            count_q <= load_val;
        end else if (dec) begin
            count_q <= count_q - 1'b1;
        end
    end

    // Zero test on the current count.
    always_comb begin
        is_zero = (count_q == '0);
    end

    assign count = count_q;

endmodule

// File: rtl/loop_shr_work.sv
// Module: working register that loads a word or shifts it right by one,
// filling the top bit with zero.
// Assumes: load and shift are never asserted together; load wins if they are.
module loop_shr_work #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    input  logic              shift,
    output logic [DATA_W-1:0] word
);

    logic [DATA_W-1:0] word_q;

    // Hold, load or shift the working word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (load) begin
            word_q <= load_val;
        end else if (shift) begin
            word_q <= {1'b0, word_q[DATA_W-1:1]};
        end
    end

    assign word = word_q;

endmodule

// File: rtl/loop_shr_ctrl.sv
// Module: control sequencer. On start it loads the immediate count and the
// operand, checks the count for zero and falls back to the register count,
// then repeats the shift step until the count is zero.
// Assumes: cnt_zero reflects the count register's present value.
module loop_shr_ctrl
    import loop_shr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic cnt_zero,
    output logic take,       // accept start: load immediate count and operand
    output logic use_reg,    // reload the count from the register source
    output logic step,       // shift once and decrement
    output logic finish,     // loop exit: publish the result
    output logic busy
);

    shr_phase_t phase_q, phase_d;

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
        end else begin
            phase_q <= phase_d;
        end
    end

    // Next phase and control strobes.
    always_comb begin
        phase_d = phase_q;
        take    = 1'b0;
        use_reg = 1'b0;
        step    = 1'b0;
        finish  = 1'b0;
        unique case (phase_q)
            PH_IDLE: begin
                if (start) begin
                    take    = 1'b1;
                    phase_d = PH_SRC;
                end
            end
            PH_SRC: begin
                use_reg = cnt_zero;
                phase_d = PH_LOOP;
            end
            PH_LOOP: begin
                if (cnt_zero) begin
                    finish  = 1'b1;
                    phase_d = PH_IDLE;
                end else begin
                    step = 1'b1;
                end
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    assign busy = (phase_q != PH_IDLE);

endmodule

// File: rtl/loop_shr_seq.sv
// Module: top of the looping shift-right sequencer. It ties the count
// register, working register and controller together, latches the fallback
// count at start, and registers the result and done pulse.
// Assumes: inputs are sampled only on the edge that accepts start.
module loop_shr_seq #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] operand,
    input  logic [CNT_W-1:0]  imm_count,
    input  logic [CNT_W-1:0]  reg_count,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] result
);

    logic              take, use_reg, step, finish, cnt_zero;
    logic [CNT_W-1:0]  cnt_val, cnt_load_val, reg_cnt_q;
    logic [DATA_W-1:0] work_val;
    logic [DATA_W-1:0] result_q;
    logic              done_q;

    // Controller.
    loop_shr_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .cnt_zero (cnt_zero),
        .take     (take),
        .use_reg  (use_reg),
        .step     (step),
        .finish   (finish),
        .busy     (busy)
    );

    // Count source: immediate at accept, latched register count on fallback.
    always_comb begin
        cnt_load_val = take ? imm_count : reg_cnt_q;
    end

    // Latch the fallback count with the other operands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_cnt_q <= '0;
        end else if (take) begin
            reg_cnt_q <= reg_count;
        end
    end

    // Shift count register.
    loop_shr_count #(.CNT_W(CNT_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (take | use_reg),
        .load_val (cnt_load_val),
        .dec      (step),
        .count    (cnt_val),
        .is_zero  (cnt_zero)
    );

    // Working register.
    loop_shr_work #(.DATA_W(DATA_W)) u_work (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (take),
        .load_val (operand),
        .shift    (step),
        .word     (work_val)
    );

    // Publish the result and raise done for one cycle at loop exit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= finish;
            if (finish) begin
                result_q <= work_val;
            end
        end
    end

    assign done   = done_q;
    assign result = result_q;

endmodule

// File: rtl/loop_shr_seq_chk.sv
// Module: property checker for loop_shr_seq, attached by bind.
// Assumes: it observes the top's ports and internal count and work signals.
module loop_shr_seq_chk #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic [DATA_W-1:0] result,
    input logic              step,
    input logic [CNT_W-1:0]  cnt_val,
    input logic [DATA_W-1:0] work_val
);

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6

    AST_STEP_DECREMENTS: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (cnt_val == CNT_W'($past(cnt_val) - 1'b1))); // R2

    AST_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (!work_val[DATA_W-1] && work_val[DATA_W-2:0] == $past(work_val[DATA_W-1:1]))); // R4

    AST_START_ACCEPTED: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy); // R7

    AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R7

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result)); // R8

endmodule

bind loop_shr_seq loop_shr_seq_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .result   (result),
    .step     (step),
    .cnt_val  (cnt_val),
    .work_val (work_val)
);

// File: tb/loop_shr_seq_tb.sv
// Scoreboard bench: the driver queues expected word and due edge; the monitor
// compares them on falling edges whenever done is high.
module loop_shr_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] operand = '0;
    logic [4:0]  imm_count = '0;
    logic [4:0]  reg_count = '0;
    logic        busy, done;
    logic [31:0] result;

    int          edge_no = 0;
    int          n_checks = 0;
    int          n_errors = 0;
    logic [31:0] exp_word_q[$];
    int          exp_edge_q[$];
    logic        finished = 1'b0;

    loop_shr_seq u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .operand   (operand),
        .imm_count (imm_count),
        .reg_count (reg_count),
        .busy      (busy),
        .done      (done),
        .result    (result)
    );

    always #4 clk = ~clk;   // 8 ns period

    always @(posedge clk) edge_no <= edge_no + 1;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver: pulse start for one cycle and queue the expected outcome.
    task automatic drive(input logic [31:0] op, input logic [4:0] imm,
                         input logic [4:0] rc, input bit expect_take);
        int n;
        @(negedge clk);
        operand = op; imm_count = imm; reg_count = rc; start = 1'b1;
        n = (imm != 0) ? int'(imm) : int'(rc);
        if (expect_take) begin
            exp_word_q.push_back(op >> n);
            exp_edge_q.push_back(edge_no + 1 + n + 2);
        end
        @(negedge clk);
        start = 1'b0;
        operand = 32'hDEAD_BEEF; imm_count = 5'd3; reg_count = 5'd9;
    endtask

    task automatic wait_empty();
        while (exp_word_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor: compare each done against the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_word_q.size() == 0) begin
                check(1'b0, "R7 unexpected done", result, 32'h0);
            end else begin
                logic [31:0] w;
                int          e;
                w = exp_word_q.pop_front();
                e = exp_edge_q.pop_front();
                check(result === w, "R2/R3/R4/R5 result", result, w);
                check(edge_no == e, "R6 done edge", 32'(edge_no), 32'(e));
                @(negedge clk);
                check(done === 1'b0, "R6 done width", {31'b0, done}, 32'h0);
                check(result === w, "R8 result held", result, w);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(done === 1'b0 && busy === 1'b0, "R1 flags in reset",
              {30'b0, busy, done}, 32'h0);
        check(result === 32'h0, "R1 result in reset", result, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(done === 1'b0 && busy === 1'b0 && result === 32'h0, "R1 after reset",
              result, 32'h0);

        // R2: immediate count used, register count ignored
        drive(32'hF0F0_1234, 5'd4, 5'd9, 1'b1);
        check(busy === 1'b1, "R7 busy after start", {31'b0, busy}, 32'h1);
        wait_empty();
        drive(32'h8000_0001, 5'd1, 5'd31, 1'b1);   // R2 shift by one
        wait_empty();

        // R3: immediate zero, register count used
        drive(32'hA5A5_5A5A, 5'd0, 5'd7, 1'b1);
        wait_empty();

        // R4: zero fill with all-ones operand, maximal count
        drive(32'hFFFF_FFFF, 5'd31, 5'd0, 1'b1);
        wait_empty();
        drive(32'hFFFF_FFFF, 5'd0, 5'd16, 1'b1);   // R4 via R3 path
        wait_empty();

        // R5: both counts zero, pass through
        drive(32'h1357_9BDF, 5'd0, 5'd0, 1'b1);
        wait_empty();

        // R7: start while busy is ignored
        drive(32'hC000_0000, 5'd10, 5'd0, 1'b1);
        drive(32'h0000_FFFF, 5'd2, 5'd0, 1'b0);
        drive(32'h1234_5678, 5'd0, 5'd5, 1'b0);
        check(busy === 1'b1, "R7 still busy", {31'b0, busy}, 32'h1);
        wait_empty();
        repeat (20) @(negedge clk);   // no extra done must appear
        check(busy === 1'b0, "R7 idle after ignored starts", {31'b0, busy}, 32'h0);
        check(result === 32'h0030_0000, "R8 result unchanged", result, 32'h0030_0000);

        // Back-to-back sequences
        drive(32'h0F00_0000, 5'd8, 5'd0, 1'b1);
        while (!done) @(negedge clk);
        drive(32'h0000_0100, 5'd0, 5'd3, 1'b1);
        wait_empty();

        check(exp_word_q.size() == 0, "R6 scoreboard drained",
              32'(exp_word_q.size()), 32'h0);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule